// File: doc/BRIEF.md
# Dual-Bank Slot Selector Harness

This block is a test-access harness for a shared die that hosts twelve identical copies of a small registered arithmetic unit. Every copy sees the same eleven data and control inputs (two 4-bit operands, a carry input and a 2-bit operation code) and runs from one single-phase clock. The copies are grouped into a low bank and a high bank of six. Each bank drives its own 5-bit output through an eight-way selector, and both selectors follow one shared 3-bit view code.

View codes 0 to 5 present one slot of each bank. Code 6 echoes the captured inputs so that a tester can confirm every input pin reaches the core intact. Code 7 presents a divide-by-two of the clock so that clock delivery can be seen at the outputs. Inside each slot the operands and the operation are registered, a single adder forms the result, and the result is registered again. The selectors themselves hold no state.

Top module: `slot_bank_harness`

## Requirements
- R1: There are two banks of six slots, and every slot receives the same operand, carry and operation inputs. View codes 0 to 5 present slot number code+1 on the low bank and slot number code+7 on the high bank. Each slot output is 5 bits, carry-out in bit 4 and the 4-bit result in bits 3:0.
- R2: A slot computes A + Y + carry_in. Y is 0 for op_code 00, B for op_code 01, the bitwise inverse of B for op_code 10 and all ones for op_code 11. With carry_in 0 this gives transfer, add, add-inverse and decrement; with carry_in 1 it gives increment, add-plus-one, subtract and transfer.
- R3: A slot result appears at the outputs after the second rising clock edge that follows the inputs being applied.
- R4: The carry-out is the carry out of the 4-bit sum. Decrementing 0 with carry_in 0 gives 5'b01111, and A+B+1 with A=B=15 gives 5'b11111.
- R5: View code 6 presents registered inputs one rising edge after they are applied. The low bank shows {carry_in, A}, and the high bank shows {op_code[1] XOR op_code[0], B}.
- R6: View code 7 presents a clock test pattern on both banks. Bit 0 is 0 out of reset and inverts on every rising edge, and bits 4:1 are 0.
- R7: The view code reaches the outputs combinationally, so a change of code changes the outputs within the same clock cycle.
- R8: The active-low reset clears every slot, the echo register and the clock pattern, so all eight view codes read 0 before the first rising edge after release.
- R9: Both banks follow the same view code, so for codes 0 to 5 the two bank outputs are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock shared by all slots |
| rst_n | input | 1 | Asynchronous active-low reset |
| opd_a | input | 4 | Operand A, common to all slots |
| opd_b | input | 4 | Operand B, common to all slots |
| carry_in | input | 1 | Carry input, common to all slots |
| op_code | input | 2 | Operation code, common to all slots |
| view_sel | input | 3 | Shared view code for both bank selectors |
| bank_lo_q | output | 5 | Low bank output (slots 1 to 6 or a test view) |
| bank_hi_q | output | 5 | High bank output (slots 7 to 12 or a test view) |

## Verification
Results arrive with three different delays. A slot result appears two rising edges after its inputs, the input echo appears one edge after, and a change of view code shows the same cycle. The bench models the two register stages and the toggle behaviourally, and updates the model on each rising edge. On the falling edge it sweeps all eight view codes, waiting a nanosecond after each one, so every sample falls after the edge that produced the value and before the next. Directed vectors hold their inputs for two edges before a literal carry or wrap value is compared.

// File: rtl/slot_harness_pkg.sv
`timescale 1ns/1ps
package slot_harness_pkg;

   // Operation selected for the second adder operand
   typedef enum logic [1:0] {
      OP_PASS = 2'b00,   // Y = 0
      OP_ADD  = 2'b01,   // Y = B
      OP_SUBB = 2'b10,   // Y = ~B
      OP_DEC  = 2'b11    // Y = all ones
   } op_e;

   localparam int unsigned OP_W        = 2;
   localparam int unsigned BANK_COUNT  = 2;
   localparam int unsigned EXTRA_VIEWS = 2;   // echo view and clock view

   // Parity of the operation code as shown on the high-bank echo view
   function automatic logic op_parity(input logic [OP_W-1:0] op);
      return ^op;
   endfunction

endpackage

// File: rtl/slot_alu_cell.sv
`timescale 1ns/1ps
module slot_alu_cell
   import slot_harness_pkg::*;
#(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opd_a,
   input  logic [DATA_W-1:0] opd_b,
   input  logic              carry_in,
   input  logic [OP_W-1:0]   op_in,
   output logic [DATA_W:0]   res_q
);

   localparam int unsigned SUM_W = DATA_W + 1;

   initial begin
      AST_CFG_DATA_W: assert (DATA_W >= 1 && DATA_W <= 32)
         else $error("slot_alu_cell: DATA_W out of range");
   end

   logic [DATA_W-1:0] a_q, b_q, y_opnd;
   logic              cin_q;
   op_e               op_q;
   logic [SUM_W-1:0]  sum_w;

   // Stage 1: capture the shared inputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         cin_q <= 1'b0;
         op_q  <= OP_PASS;
      end else begin
         a_q   <= opd_a;
         b_q   <= opd_b;
         cin_q <= carry_in;
         op_q  <= op_e'(op_in);
      end
   end

   // Second operand selection
   always_comb begin
      unique case (op_q)
         OP_PASS: y_opnd = '0;
         OP_ADD:  y_opnd = b_q;
         OP_SUBB: y_opnd = ~b_q;
         default: y_opnd = '1;
      endcase
   end

   assign sum_w = {1'b0, a_q} + {1'b0, y_opnd} + {{DATA_W{1'b0}}, cin_q};

   // Stage 2: register carry and result together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= sum_w;
   end

   AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_PASS && !cin_q) |=> res_q == {1'b0, $past(a_q)}); // R2

   AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_PASS && cin_q && a_q == '1) |=> res_q == {1'b1, {DATA_W{1'b0}}}); // R4

   AST_DEC_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_DEC && a_q == '0 && !cin_q) |=> res_q == {1'b0, {DATA_W{1'b1}}}); // R4

   AST_DEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_DEC && (a_q != '0 || cin_q)) |=> res_q[DATA_W]); // R4

   AST_SUB_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_SUBB && cin_q && a_q == b_q) |=> res_q == {1'b1, {DATA_W{1'b0}}}); // R2

endmodule

// File: rtl/harness_view_gen.sv
`timescale 1ns/1ps
module harness_view_gen
   import slot_harness_pkg::*;
#(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opd_a,
   input  logic [DATA_W-1:0] opd_b,
   input  logic              carry_in,
   input  logic [OP_W-1:0]   op_in,
   output logic [DATA_W:0]   echo_lo_q,
   output logic [DATA_W:0]   echo_hi_q,
   output logic [DATA_W:0]   clk_pat
);

   localparam int unsigned OUT_W = DATA_W + 1;

   logic tog_q;

   // Registered input echo for pin-integrity checks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         echo_lo_q <= '0;
         echo_hi_q <= '0;
      end else begin
         echo_lo_q <= {carry_in, opd_a};
         echo_hi_q <= {op_parity(op_in), opd_b};
      end
   end

   // Divide-by-two of the distributed clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= ~tog_q;
   end

   assign clk_pat = {{(OUT_W-1){1'b0}}, tog_q};

   AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> clk_pat[0] != $past(clk_pat[0])); // R6

   AST_ECHO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> echo_hi_q[DATA_W] == ($past(op_in) == 2'b01 || $past(op_in) == 2'b10)); // R5

   AST_ECHO_CARRY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carry_in) |=> echo_lo_q[DATA_W]); // R5

endmodule

// File: rtl/bank_view_mux.sv
`timescale 1ns/1ps
module bank_view_mux #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned SEL_W = 3,
   parameter int unsigned W     = 5
) (
   input  logic [W-1:0]     src [N_SRC],
   input  logic [SEL_W-1:0] sel,
   output logic [W-1:0]     y
);

   initial begin
      AST_CFG_MUX_FIT: assert (N_SRC >= 1 && N_SRC <= (1 << SEL_W))
         else $error("bank_view_mux: N_SRC does not fit SEL_W");
   end

   // Purely combinational selection; codes beyond N_SRC read zero
   always_comb begin
      y = '0;
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (sel == SEL_W'(i)) y = src[i];
      end
   end

endmodule

// File: rtl/slot_bank_harness.sv
`timescale 1ns/1ps
module slot_bank_harness
   import slot_harness_pkg::*;
#(
   parameter int unsigned DATA_W         = 4,
   parameter int unsigned SLOTS_PER_BANK = 6,
   parameter int unsigned SEL_W          = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opd_a,
   input  logic [DATA_W-1:0] opd_b,
   input  logic              carry_in,
   input  logic [1:0]        op_code,
   input  logic [SEL_W-1:0]  view_sel,
   output logic [DATA_W:0]   bank_lo_q,
   output logic [DATA_W:0]   bank_hi_q
);

   localparam int unsigned OUT_W     = DATA_W + 1;
   localparam int unsigned N_SRC     = 1 << SEL_W;
   localparam int unsigned NUM_BANKS = BANK_COUNT;
   localparam int unsigned IDX_ECHO  = SLOTS_PER_BANK;
   localparam int unsigned IDX_CLOCK = SLOTS_PER_BANK + 1;
   localparam logic [SEL_W-1:0] CODE_CLOCK = SEL_W'(IDX_CLOCK);
   localparam logic [SEL_W-1:0] CODE_SLOTS = SEL_W'(SLOTS_PER_BANK);

   initial begin
      AST_CFG_VIEW_FIT: assert (SLOTS_PER_BANK + EXTRA_VIEWS <= N_SRC)
         else $error("slot_bank_harness: select too narrow for slots and test views");
      AST_CFG_SLOTS: assert (SLOTS_PER_BANK >= 1)
         else $error("slot_bank_harness: need at least one slot per bank");
   end

   logic [OUT_W-1:0] echo_lo, echo_hi, clk_pat;
   logic [OUT_W-1:0] bank_v [NUM_BANKS];

   harness_view_gen #(.DATA_W(DATA_W)) u_view_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .opd_a    (opd_a),
      .opd_b    (opd_b),
      .carry_in (carry_in),
      .op_in    (op_code),
      .echo_lo_q(echo_lo),
      .echo_hi_q(echo_hi),
      .clk_pat  (clk_pat)
   );

   for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
      logic [OUT_W-1:0] res_v [SLOTS_PER_BANK];
      logic [OUT_W-1:0] src_v [N_SRC];

      for (genvar s = 0; s < int'(SLOTS_PER_BANK); s++) begin : g_slot
         slot_alu_cell #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .opd_a   (opd_a),
            .opd_b   (opd_b),
            .carry_in(carry_in),
            .op_in   (op_code),
            .res_q   (res_v[s])
         );
      end

      for (genvar i = 0; i < int'(N_SRC); i++) begin : g_src
         if (i < int'(SLOTS_PER_BANK)) begin : g_is_slot
            assign src_v[i] = res_v[i];
         end else if (i == int'(IDX_ECHO)) begin : g_is_echo
            if (b == 0) begin : g_lo
               assign src_v[i] = echo_lo;
            end else begin : g_hi
               assign src_v[i] = echo_hi;
            end
         end else if (i == int'(IDX_CLOCK)) begin : g_is_clock
            assign src_v[i] = clk_pat;
         end else begin : g_is_spare
            assign src_v[i] = '0;
         end
      end

      bank_view_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W), .W(OUT_W)) u_mux (
         .src(src_v),
         .sel(view_sel),
         .y  (bank_v[b])
      );
   end

   assign bank_lo_q = bank_v[0];
   assign bank_hi_q = bank_v[NUM_BANKS-1];

   AST_BANKS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (view_sel < CODE_SLOTS) |-> bank_lo_q == bank_hi_q); // R9

   AST_CLOCK_VIEW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (view_sel == CODE_CLOCK) |-> (bank_lo_q[OUT_W-1:1] == '0 && bank_hi_q[OUT_W-1:1] == '0)); // R6

   AST_CLOCK_VIEW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && view_sel == CODE_CLOCK && $past(view_sel) == CODE_CLOCK)
         |-> bank_lo_q[0] != $past(bank_lo_q[0])); // R6

endmodule

// File: tb/slot_bank_harness_tb_top.sv
`timescale 1ns/1ps
module slot_bank_harness_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] opd_a = '0, opd_b = '0;
   logic       carry_in = 1'b0;
   logic [1:0] op_code = '0;
   logic [2:0] view_sel = '0;
   logic [4:0] bank_lo_q, bank_hi_q;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   slot_bank_harness dut_i (
      .clk(clk), .rst_n(rst_n), .opd_a(opd_a), .opd_b(opd_b),
      .carry_in(carry_in), .op_code(op_code), .view_sel(view_sel),
      .bank_lo_q(bank_lo_q), .bank_hi_q(bank_hi_q)
   );

   // Behavioural reference: two register stages and a toggle
   int         m_a, m_b, m_c, m_op;
   logic [4:0] m_res;
   bit         m_tog;

   function automatic logic [4:0] ref_calc(int a, int b, int c, int op);
      int y;
      case (op)
         0:       y = 0;
         1:       y = b;
         2:       y = 15 - b;
         default: y = 15;
      endcase
      return 5'(a + y + c);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_a <= 0; m_b <= 0; m_c <= 0; m_op <= 0; m_res <= '0; m_tog <= 1'b0;
      end else begin
         m_a <= int'(opd_a); m_b <= int'(opd_b); m_c <= int'(carry_in); m_op <= int'(op_code);
         m_res <= ref_calc(m_a, m_b, m_c, m_op);
         m_tog <= ~m_tog;
      end
   end

   task automatic check5(string req, int code, logic [4:0] act, logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s view %0d actual %b expected %b at %0t", req, code, act, exp, $time);
      end
   endtask

   // Sweep all eight view codes inside one cycle (R7: combinational select)
   task automatic sweep();
      for (int s = 0; s < 8; s++) begin
         logic [4:0] exp_lo, exp_hi;
         string tag;
         view_sel = 3'(s);
         #1;
         if (s < 6) begin
            exp_lo = m_res; exp_hi = m_res; tag = "R1 R2 R3 R7 R9";
         end else if (s == 6) begin
            exp_lo = {m_c[0], 4'(m_a)};
            exp_hi = {1'(m_op == 1 || m_op == 2), 4'(m_b)};
            tag = "R5 R7";
         end else begin
            exp_lo = {4'b0, m_tog}; exp_hi = {4'b0, m_tog}; tag = "R6 R7";
         end
         check5({tag, " lo"}, s, bank_lo_q, exp_lo);
         check5({tag, " hi"}, s, bank_hi_q, exp_hi);
      end
   endtask

   task automatic drive(int a, int b, int c, int op);
      opd_a = 4'(a); opd_b = 4'(b); carry_in = 1'(c); op_code = 2'(op);
   endtask

   // Hold a vector for two edges, then compare a literal (R3 latency)
   task automatic directed(string req, int a, int b, int c, int op, logic [4:0] lit);
      drive(a, b, c, op);
      @(negedge clk); sweep();
      @(negedge clk); sweep();
      view_sel = 3'd0; #1;
      check5({req, " literal lo"}, 0, bank_lo_q, lit);
      check5({req, " literal hi"}, 0, bank_hi_q, lit);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: nothing clocked since release, every view reads zero
      for (int s = 0; s < 8; s++) begin
         view_sel = 3'(s); #1;
         check5("R8 lo", s, bank_lo_q, 5'b0);
         check5("R8 hi", s, bank_hi_q, 5'b0);
      end
      directed("R4 dec-zero",  0,  5, 0, 3, 5'b01111);
      directed("R4 dec-nine",  9,  0, 1, 3, 5'b11001);
      directed("R4 add-max",  15, 15, 1, 1, 5'b11111);
      directed("R4 add-wrap", 15,  1, 0, 1, 5'b10000);
      directed("R2 sub-eq",    3,  3, 1, 2, 5'b10000);
      directed("R2 sub-neg",   2,  5, 1, 2, 5'b01101);
      directed("R2 inc",       7,  0, 1, 0, 5'b01000);
      directed("R4 inc-wrap", 15,  0, 1, 0, 5'b10000);
      directed("R2 pass",     10,  6, 0, 0, 5'b01010);
      for (int n = 0; n < 2000; n++) begin
         drive(int'($urandom_range(15)), int'($urandom_range(15)),
               int'($urandom_range(1)), int'($urandom_range(3)));
         view_sel = 3'($urandom_range(7));
         @(negedge clk);
         sweep();
      end
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired, actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule